// File: doc/BRIEF.md
# Multi-Pattern Output Flip Locking Unit

This block guards a single output bit of a larger combinational function. It watches a group of protected input bits and compares them against a set of secret patterns fixed at build time. Whenever the inputs equal any one of those patterns, the guarded output is inverted, so a chip without the right key produces wrong results at exactly those input points.

A key input carries a second set of patterns. When the inputs equal any of the key patterns, the output is inverted again. With a key that holds the same set of patterns as the fixed set, the two inversions always cancel and the output passes through unchanged. The key is a concatenation of equal-width pattern fields, and its bit order must be followed exactly. The block is purely combinational; pattern storage and the choice of which inputs are protected belong to the surrounding logic.

Top module: `lock_flip_unit`

## Requirements
- R1: The key is PAT_W*PAT_N bits wide; bit i of key pattern j is key bit i + j*PAT_W, and the fixed patterns in HARD_PATS use the same ordering.
- R2: The flip term is 1 exactly when all PAT_W protected input bits equal some fixed pattern.
- R3: The restore term is 1 exactly when all PAT_W protected input bits equal some key pattern.
- R4: The output equals the original bit XOR flip term XOR restore term; when both terms are 1 the output equals the original bit.
- R5: With a key equal to HARD_PATS, the output equals the original bit for every protected input value.
- R6: Identical fixed patterns give a single inversion at their shared value, never a double one.
- R7: A key with one pattern field wrong corrupts the output at exactly two input values: the fixed pattern it should hold and the wrong value it holds (when neither equals another pattern).
- R8: The output follows any input change with no clock and no latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| prot_in | input | PAT_W | Protected input bits compared against all patterns |
| orig_out | input | 1 | Original, unprotected output bit |
| key_in | input | PAT_W*PAT_N | Concatenated key patterns, pattern j at bits j*PAT_W upward |
| locked_out | output | 1 | Guarded output bit |

## Verification
Every protected input value is swept with both values of the original bit under several keys: the correct key (transparent everywhere), an all-ones key that matches nothing fixed (shows the raw corruption points and one restore point), a key with one field replaced (shows exactly two wrong points and tells field ordering apart), and keys whose fields are shuffled or partly correct. A second instance with duplicated fixed patterns tells a single inversion from a double one. Changing the inputs between clock edges shows the output has no latency.

// File: rtl/lock_flip_pkg.sv
package lock_flip_pkg;
    // Position of bit i of pattern j inside a concatenated pattern vector.
    function automatic int key_bit_pos(input int bit_i, input int pat_j, input int width);
        return bit_i + pat_j * width;
    endfunction
endpackage

// File: rtl/lock_flip_match.sv
module lock_flip_match #(
    parameter int PAT_W = 4
) (
    input  logic [PAT_W-1:0] sample_bits,
    input  logic [PAT_W-1:0] pattern_bits,
    output logic             is_equal
);
    logic [PAT_W-1:0] bit_same;

    for (genvar b = 0; b < PAT_W; b++) begin : g_bit
        // inverted difference: 1 when the two bits agree
        assign bit_same[b] = ~(sample_bits[b] ^ pattern_bits[b]);
    end

    assign is_equal = &bit_same;
endmodule

// File: rtl/lock_flip_bank.sv
module lock_flip_bank
    import lock_flip_pkg::*;
#(
    parameter int PAT_W = 4,
    parameter int PAT_N = 3,
    localparam int VEC_W = PAT_W * PAT_N
) (
    input  logic [PAT_W-1:0] sample_bits,
    input  logic [VEC_W-1:0] pattern_vec,
    output logic             any_hit
);
    logic [PAT_N-1:0] hit_per_pat;

    for (genvar j = 0; j < PAT_N; j++) begin : g_pat
        logic [PAT_W-1:0] field;
        for (genvar i = 0; i < PAT_W; i++) begin : g_fbit
            assign field[i] = pattern_vec[key_bit_pos(i, j, PAT_W)];
        end
        lock_flip_match #(.PAT_W(PAT_W)) u_match (
            .sample_bits (sample_bits),
            .pattern_bits(field),
            .is_equal    (hit_per_pat[j])
        );
    end

    assign any_hit = |hit_per_pat;
endmodule

// File: rtl/lock_flip_unit.sv
module lock_flip_unit #(
    parameter int PAT_W = 4,
    parameter int PAT_N = 3,
    parameter logic [PAT_W*PAT_N-1:0] HARD_PATS = 12'hC3A
) (
    input  logic [PAT_W-1:0]       prot_in,
    input  logic                   orig_out,
    input  logic [PAT_W*PAT_N-1:0] key_in,
    output logic                   locked_out
);
    logic flip_hit;
    logic restore_hit;

    lock_flip_bank #(.PAT_W(PAT_W), .PAT_N(PAT_N)) u_flip_bank (
        .sample_bits(prot_in),
        .pattern_vec(HARD_PATS),
        .any_hit    (flip_hit)
    );

    lock_flip_bank #(.PAT_W(PAT_W), .PAT_N(PAT_N)) u_restore_bank (
        .sample_bits(prot_in),
        .pattern_vec(key_in),
        .any_hit    (restore_hit)
    );

    assign locked_out = orig_out ^ flip_hit ^ restore_hit;
endmodule

// File: rtl/lock_flip_unit_chk.sv
module lock_flip_unit_chk #(
    parameter int PAT_W = 4,
    parameter int PAT_N = 3,
    parameter logic [PAT_W*PAT_N-1:0] HARD_PATS = 12'hC3A
) (
    input logic [PAT_W-1:0]       prot_in,
    input logic                   orig_out,
    input logic [PAT_W*PAT_N-1:0] key_in,
    input logic                   locked_out,
    input logic                   flip_hit,
    input logic                   restore_hit
);
    function automatic logic any_equal(input logic [PAT_W-1:0] x,
                                       input logic [PAT_W*PAT_N-1:0] vec);
        logic found;
        found = 1'b0;
        for (int j = 0; j < PAT_N; j++) begin
            if (vec[j*PAT_W +: PAT_W] == x) found = 1'b1;
        end
        return found;
    endfunction

    always_comb begin
        assert_flip_match_R2: assert (flip_hit == any_equal(prot_in, HARD_PATS))
            else $error("flip term disagrees with fixed patterns");
        assert_restore_match_R3: assert (restore_hit == any_equal(prot_in, key_in))
            else $error("restore term disagrees with key patterns");
        // R4: equal terms cancel, unequal terms invert
        assert_output_combine_R4: assert ((flip_hit == restore_hit) ? (locked_out == orig_out)
                                                                    : (locked_out != orig_out))
            else $error("output combination wrong");
        assert_transparent_key_R5: assert ((key_in != HARD_PATS) || (locked_out == orig_out))
            else $error("correct key not transparent");
    end
endmodule

bind lock_flip_unit lock_flip_unit_chk #(
    .PAT_W(PAT_W), .PAT_N(PAT_N), .HARD_PATS(HARD_PATS)
) u_chk (
    .prot_in    (prot_in),
    .orig_out   (orig_out),
    .key_in     (key_in),
    .locked_out (locked_out),
    .flip_hit   (flip_hit),
    .restore_hit(restore_hit)
);

// File: tb/lock_flip_unit_test.sv
`timescale 1ns/1ps
module lock_flip_unit_test;
    localparam logic [11:0] HARD     = 12'hC3A; // p0=A p1=3 p2=C
    localparam logic [11:0] HARD_DUP = 12'hAA6; // p0=6 p1=A p2=A

    logic       clk = 1'b0;
    logic [3:0] prot_in = '0;
    logic       orig_out = 1'b0;
    logic [11:0] key_in = '0;
    logic [11:0] key_dup = '0;
    logic       locked_out;
    logic       locked_dup;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    lock_flip_unit #(.PAT_W(4), .PAT_N(3), .HARD_PATS(HARD)) uut (
        .prot_in(prot_in), .orig_out(orig_out), .key_in(key_in), .locked_out(locked_out));

    lock_flip_unit #(.PAT_W(4), .PAT_N(3), .HARD_PATS(HARD_DUP)) uut_dup (
        .prot_in(prot_in), .orig_out(orig_out), .key_in(key_dup), .locked_out(locked_dup));

    // Expected output from the requirements: field j occupies bits j*4 upward.
    function automatic logic model(input logic [3:0] x, input logic o,
                                   input logic [11:0] k, input logic [11:0] h);
        logic f;
        logic r;
        f = 1'b0;
        r = 1'b0;
        for (int j = 0; j < 3; j++) begin
            if (h[j*4 +: 4] == x) f = 1'b1;
            if (k[j*4 +: 4] == x) r = 1'b1;
        end
        return o ^ f ^ r;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s x=%h orig=%b actual=%b expected=%b", req, prot_in, orig_out, act, exp);
        end
    endtask

    task automatic sweep_main(input string req, input logic [11:0] k);
        key_in = k;
        for (int x = 0; x < 16; x++) begin
            for (int o = 0; o < 2; o++) begin
                @(negedge clk);
                prot_in  = 4'(x);
                orig_out = 1'(o);
                #1;
                check(req, locked_out, model(4'(x), 1'(o), k, HARD));
            end
        end
    endtask

    initial begin
        int wrong_pts;
        // initial state: zero inputs, correct key
        key_in = HARD;
        key_dup = HARD_DUP;
        @(negedge clk);
        #1;
        check("R8 init", locked_out, 1'b0);

        sweep_main("R5 correct key", HARD);
        sweep_main("R2 no matching key", 12'hFFF);
        sweep_main("R1 field order key", 12'hC35);
        sweep_main("R3 shuffled key", 12'h3AC);
        sweep_main("R4 partial key", 12'h0A0);

        // R7: field 1 holds 7 instead of 3
        key_in = 12'hC7A;
        wrong_pts = 0;
        for (int x = 0; x < 16; x++) begin
            @(negedge clk);
            prot_in = 4'(x);
            orig_out = 1'b0;
            #1;
            check("R7 one wrong field", locked_out, (x == 3 || x == 7) ? 1'b1 : 1'b0);
            if (locked_out) wrong_pts++;
        end
        total++;
        if (wrong_pts != 2) begin
            bad++;
            $display("FAIL R7 corrupted count actual=%0d expected=2", wrong_pts);
        end

        // R6: duplicated fixed patterns
        key_dup = 12'h000;
        for (int x = 0; x < 16; x++) begin
            @(negedge clk);
            prot_in = 4'(x);
            orig_out = 1'b1;
            #1;
            check("R6 duplicate flip", locked_dup, model(4'(x), 1'b1, 12'h000, HARD_DUP));
        end
        @(negedge clk);
        prot_in = 4'hA;
        orig_out = 1'b0;
        #1;
        check("R6 single inversion at shared value", locked_dup, 1'b1);
        key_dup = HARD_DUP;
        for (int x = 0; x < 16; x++) begin
            @(negedge clk);
            prot_in = 4'(x);
            orig_out = 1'b1;
            #1;
            check("R6 duplicate transparent", locked_dup, 1'b1);
        end

        // R8: changes between edges show up at once
        key_in = 12'hFFF;
        @(posedge clk);
        #2;
        prot_in = 4'h3;
        orig_out = 1'b0;
        #1;
        check("R8 no latency hit", locked_out, 1'b1);
        prot_in = 4'h4;
        #1;
        check("R8 no latency miss", locked_out, 1'b0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule